// File: doc/BRIEF.md
# DRAM Rank Power State Tracker

This block follows the operating power state of a single DRAM rank, one clock cycle at a time. It watches the commands the controller issues to the rank: bank open and bank close strobes carrying a bank number, a close-all strobe, refresh begin and refresh end strobes from the refresh sequencer, and power-down enter and exit requests. From these it keeps the rank state, the number of open banks and a per-state residency count. A power or thermal model reads these outputs, and so does any logic that must know whether the rank may be refreshed or powered down.

A transition can be booked for a future cycle and held apart from the current state. Two things book one. When the last open bank closes, a move to the idle state is booked for the cycle at which the precharge completes. When the rank enters idle, a move to precharge power-down is booked after a programmable delay. A later command can cancel a booked move or replace it with a newer one. An activate that arrives before the booked move to idle takes effect is the main case, and it keeps the rank active.

Cycle numbers are counted by an internal cycle counter. It is 0 at the first rising edge after reset is released and rises by one at every edge. The "cycle of an edge" is the counter value at that edge.

Top module: `rank_pwr_tracker`

## Requirements
- R1: While reset is held and right after it, the state is idle, the open-bank count is 0, nothing is pending, all residency counters and the last-change stamp are 0, and the error flag is low.
- R2: The state output encodes idle=0, refresh=1, precharge power-down=2, active=3 and active power-down=4. The state is idle only when the open-bank count is 0.
- R3: An activate accepted in idle or active opens the addressed bank. The count rises by one only if that bank was closed. An activate from idle makes the state active after that edge.
- R4: A precharge of an open bank lowers the count by one. A precharge of a closed bank has no effect. Close-all brings the count to 0.
- R5: In the active state, a precharge edge at cycle t that takes the count from nonzero to 0 books a move to idle for cycle t+PRE_CYC (default 4). The state becomes idle after the edge at that cycle.
- R6: An activate before the booked cycle cancels the booking and the state stays active. A later count-to-zero books a new target from its own cycle.
- R7: From idle, refresh-begin moves to refresh and refresh-end returns to idle. Power-down request moves from idle to precharge power-down, and power-down exit returns to idle.
- R8: From active, power-down request moves to active power-down. Exit returns to active if any bank is open, and otherwise to idle.
- R9: On entering idle with a nonzero power-down delay d at cycle t, a move to precharge power-down is booked for t+d. A delay of 0 books nothing.
- R10: An activate in refresh, precharge power-down or active power-down is ignored: no bank opens and the state does not change. It sets an error flag that only reset clears.
- R11: At every edge, the residency counter of the state held before that edge rises by one, so the five counters sum to the cycle counter.
- R12: The last-change stamp holds the cycle of the most recent edge that changed the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_vld | input | 1 | Activate strobe |
| act_bank | input | BANK_W | Bank to open |
| pre_vld | input | 1 | Precharge strobe |
| pre_bank | input | BANK_W | Bank to close |
| pre_all | input | 1 | Close every bank |
| ref_start | input | 1 | Refresh begins |
| ref_done | input | 1 | Refresh ends |
| pdn_req | input | 1 | Power-down enter request |
| pdn_exit | input | 1 | Power-down exit |
| pdn_dly | input | DLY_W | Idle-to-power-down delay in cycles, 0 disables |
| cur_state | output | 3 | Current power state |
| open_banks | output | CNT_W | Number of open banks |
| pend_vld | output | 1 | A transition is booked |
| pend_state | output | 3 | Booked target state |
| pend_at | output | TS_W | Cycle at which the booked move takes effect |
| last_chg_at | output | TS_W | Cycle of the last state change |
| res_cycles | output | 5*TS_W | Residency counters, state k in bits k*TS_W upward |
| act_err | output | 1 | Sticky illegal-activate flag |

## Verification
The hardest situation to reach is a booked move to idle that a late activate overrides. The stimulus closes the last bank, checks the booked target, and then opens a new bank within the PRE_CYC window. It then waits beyond the old target to show that the state stays active. After that it closes the bank again and checks that the new target counts from the new cycle. The automatic power-down booking is reached in a similar way: the rank passes through refresh with a nonzero delay, so it enters idle by a path other than precharge. A power-down exit is then cut short by an activate.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;
  typedef enum logic [2:0] {
    PS_IDLE    = 3'd0,
    PS_REF     = 3'd1,
    PS_PRE_PDN = 3'd2,
    PS_ACT     = 3'd3,
    PS_ACT_PDN = 3'd4
  } pwr_st_e;

  localparam int NUM_ST = 5;
endpackage

// File: rtl/rpt_bank_track.sv
module rpt_bank_track #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_en,
  input  logic [BANK_W-1:0] act_bank,
  input  logic              pre_vld,
  input  logic [BANK_W-1:0] pre_bank,
  input  logic              pre_all,
  output logic [CNT_W-1:0]  open_cnt,
  output logic              cnt_to_zero
);
  logic [NUM_BANKS-1:0] open_mask, mask_nxt;
  logic [CNT_W-1:0]     cnt_nxt;

  function automatic logic [CNT_W-1:0] pop_cnt(input logic [NUM_BANKS-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NUM_BANKS; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  always_comb begin
    mask_nxt = open_mask;
    if (pre_all) mask_nxt = '0;
    else if (pre_vld) mask_nxt[pre_bank] = 1'b0;
    if (open_en && !pre_all) mask_nxt[act_bank] = 1'b1;
    cnt_nxt     = pop_cnt(mask_nxt);
    cnt_to_zero = (open_cnt != '0) && (cnt_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_mask <= '0;
      open_cnt  <= '0;
    end else begin
      open_mask <= mask_nxt;
      open_cnt  <= cnt_nxt;
    end
  end

  // R4
  zero_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_to_zero |=> open_cnt == '0);

  // R3
  open_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_en && !pre_vld && !pre_all) |=> open_cnt != '0);
endmodule

// File: rtl/rpt_state_ctl.sv
module rpt_state_ctl
  import rank_pwr_pkg::*;
#(
  parameter int TS_W    = 32,
  parameter int DLY_W   = 8,
  parameter int CNT_W   = 4,
  parameter int PRE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  now,
  input  logic             act_vld,
  input  logic             ref_start,
  input  logic             ref_done,
  input  logic             pdn_req,
  input  logic             pdn_exit,
  input  logic [DLY_W-1:0] pdn_dly,
  input  logic [CNT_W-1:0] open_cnt,
  input  logic             cnt_to_zero,
  output logic             act_ok,
  output pwr_st_e          st,
  output logic             pend_vld,
  output pwr_st_e          pend_st,
  output logic [TS_W-1:0]  pend_at,
  output logic [TS_W-1:0]  last_chg_at,
  output logic             act_err
);
  pwr_st_e         st_n, ps_n;
  logic            pv_n, fire_ev, act_bad;
  logic [TS_W-1:0] pa_n;

  function automatic logic [TS_W-1:0] book_at(input logic [TS_W-1:0] t,
                                              input logic [TS_W-1:0] d);
    return t + d;
  endfunction

  assign act_ok  = act_vld && (st == PS_IDLE || st == PS_ACT);
  assign act_bad = act_vld && !act_ok;
  assign fire_ev = pend_vld && (now == pend_at);

  always_comb begin
    st_n = st;
    pv_n = pend_vld;
    ps_n = pend_st;
    pa_n = pend_at;
    if (fire_ev) begin
      pv_n = 1'b0;
      st_n = pend_st;
    end
    case (st)
      PS_IDLE: begin
        if (act_ok) begin
          st_n = PS_ACT;
          pv_n = 1'b0;
        end else if (ref_start) begin
          st_n = PS_REF;
          pv_n = 1'b0;
        end else if (pdn_req) begin
          st_n = PS_PRE_PDN;
          pv_n = 1'b0;
        end
      end
      PS_REF:     if (ref_done) st_n = PS_IDLE;
      PS_PRE_PDN: if (pdn_exit) st_n = PS_IDLE;
      PS_ACT: begin
        if (act_ok) begin
          st_n = PS_ACT;
          pv_n = 1'b0;
        end else if (pdn_req) begin
          st_n = PS_ACT_PDN;
          pv_n = 1'b0;
        end else if (cnt_to_zero) begin
          pv_n = 1'b1;
          ps_n = PS_IDLE;
          pa_n = book_at(now, TS_W'(PRE_CYC));
        end
      end
      PS_ACT_PDN: if (pdn_exit) st_n = (open_cnt != '0) ? PS_ACT : PS_IDLE;
      default:    st_n = PS_IDLE;
    endcase
    if (st_n == PS_IDLE && st != PS_IDLE && pdn_dly != '0) begin
      pv_n = 1'b1;
      ps_n = PS_PRE_PDN;
      pa_n = book_at(now, TS_W'(pdn_dly));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= PS_IDLE;
      pend_vld    <= 1'b0;
      pend_st     <= PS_IDLE;
      pend_at     <= '0;
      last_chg_at <= '0;
      act_err     <= 1'b0;
    end else begin
      st       <= st_n;
      pend_vld <= pv_n;
      pend_st  <= ps_n;
      pend_at  <= pa_n;
      if (st_n != st) last_chg_at <= now;
      if (act_bad) act_err <= 1'b1;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_err |=> act_err);

  // R10
  bad_act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_bad && !pdn_exit && !ref_done) |=> $stable(st));

  // R5
  fire_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_ev && !act_vld && !pdn_req && !ref_start) |=> st == $past(pend_st));

  // R8
  act_pdn_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) != PS_ACT && $past(st) != PS_ACT_PDN) |-> st != PS_ACT_PDN);

  // R12
  stamp_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> last_chg_at == now - 1'b1);
endmodule

// File: rtl/rpt_residency.sv
module rpt_residency
  import rank_pwr_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  pwr_st_e                st,
  output logic [TS_W-1:0]        now,
  output logic [NUM_ST*TS_W-1:0] res_flat
);
  localparam int SUM_W = TS_W + 3;

  logic [TS_W-1:0]  res_q [NUM_ST];
  logic [SUM_W-1:0] res_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  for (genvar k = 0; k < NUM_ST; k++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n) res_q[k] <= '0;
      else if (st == pwr_st_e'(k)) res_q[k] <= res_q[k] + 1'b1;
    end
    assign res_flat[k*TS_W +: TS_W] = res_q[k];
  end

  always_comb begin
    res_sum = '0;
    for (int k = 0; k < NUM_ST; k++) res_sum = res_sum + SUM_W'(res_q[k]);
  end

  // R11
  res_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_sum == SUM_W'(now));
endmodule

// File: rtl/rank_pwr_tracker.sv
module rank_pwr_tracker
  import rank_pwr_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TS_W      = 32,
  parameter int DLY_W     = 8,
  parameter int PRE_CYC   = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(NUM_BANKS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   act_vld,
  input  logic [BANK_W-1:0]      act_bank,
  input  logic                   pre_vld,
  input  logic [BANK_W-1:0]      pre_bank,
  input  logic                   pre_all,
  input  logic                   ref_start,
  input  logic                   ref_done,
  input  logic                   pdn_req,
  input  logic                   pdn_exit,
  input  logic [DLY_W-1:0]       pdn_dly,
  output logic [2:0]             cur_state,
  output logic [CNT_W-1:0]       open_banks,
  output logic                   pend_vld,
  output logic [2:0]             pend_state,
  output logic [TS_W-1:0]        pend_at,
  output logic [TS_W-1:0]        last_chg_at,
  output logic [NUM_ST*TS_W-1:0] res_cycles,
  output logic                   act_err
);
  pwr_st_e         st, pend_st;
  logic            act_ok, cnt_to_zero;
  logic [TS_W-1:0] now;

  rpt_bank_track #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .CNT_W(CNT_W)
  ) u_banks (
    .clk(clk), .rst_n(rst_n), .open_en(act_ok), .act_bank(act_bank),
    .pre_vld(pre_vld), .pre_bank(pre_bank), .pre_all(pre_all),
    .open_cnt(open_banks), .cnt_to_zero(cnt_to_zero)
  );

  rpt_state_ctl #(
    .TS_W(TS_W), .DLY_W(DLY_W), .CNT_W(CNT_W), .PRE_CYC(PRE_CYC)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .now(now), .act_vld(act_vld),
    .ref_start(ref_start), .ref_done(ref_done), .pdn_req(pdn_req),
    .pdn_exit(pdn_exit), .pdn_dly(pdn_dly), .open_cnt(open_banks),
    .cnt_to_zero(cnt_to_zero), .act_ok(act_ok), .st(st),
    .pend_vld(pend_vld), .pend_st(pend_st), .pend_at(pend_at),
    .last_chg_at(last_chg_at), .act_err(act_err)
  );

  rpt_residency #(.TS_W(TS_W)) u_res (
    .clk(clk), .rst_n(rst_n), .st(st), .now(now), .res_flat(res_cycles)
  );

  assign cur_state  = st;
  assign pend_state = pend_st;

  // R2
  idle_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == PS_IDLE |-> open_banks == '0);
endmodule

// File: tb/rank_pwr_tracker_bench.sv
module rank_pwr_tracker_bench;
  localparam int TS_W = 32;
  localparam int PRE  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_vld = 0, pre_vld = 0, pre_all = 0, ref_start = 0, ref_done = 0;
  logic pdn_req = 0, pdn_exit = 0;
  logic [2:0] act_bank = '0, pre_bank = '0;
  logic [7:0] pdn_dly = '0;
  logic [2:0] cur_state, pend_state;
  logic [3:0] open_banks;
  logic pend_vld, act_err;
  logic [TS_W-1:0] pend_at, last_chg_at;
  logic [5*TS_W-1:0] res_cycles;

  int n_chk = 0, n_fail = 0;
  longint cyc = 0, t = 0;
  longint res_exp [5] = '{0, 0, 0, 0, 0};
  logic [2:0] st_neg = 3'd0;
  bit done = 0;

  always #2 clk = ~clk;

  rank_pwr_tracker u_rank_pwr_tracker (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_bank(act_bank),
    .pre_vld(pre_vld), .pre_bank(pre_bank), .pre_all(pre_all),
    .ref_start(ref_start), .ref_done(ref_done), .pdn_req(pdn_req),
    .pdn_exit(pdn_exit), .pdn_dly(pdn_dly), .cur_state(cur_state),
    .open_banks(open_banks), .pend_vld(pend_vld), .pend_state(pend_state),
    .pend_at(pend_at), .last_chg_at(last_chg_at), .res_cycles(res_cycles),
    .act_err(act_err)
  );

  always @(negedge clk) st_neg = cur_state;
  always @(posedge clk) if (rst_n) begin
    cyc++;
    res_exp[st_neg]++;
  end

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic strobe_end();
    t = cyc;
    @(negedge clk);
    act_vld = 0; pre_vld = 0; pre_all = 0; ref_start = 0; ref_done = 0;
    pdn_req = 0; pdn_exit = 0;
  endtask

  task automatic do_act(input int b);
    act_vld = 1; act_bank = 3'(b); strobe_end();
  endtask
  task automatic do_pre(input int b);
    pre_vld = 1; pre_bank = 3'(b); strobe_end();
  endtask
  task automatic do_pre_all();
    pre_all = 1; strobe_end();
  endtask

  task automatic wait_to(input longint c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "state in reset", cur_state, 0);
    chk("R1", "count in reset", open_banks, 0);
    chk("R1", "pending in reset", pend_vld, 0);
    chk("R1", "err in reset", act_err, 0);
    chk("R1", "stamp in reset", last_chg_at, 0);
    for (int k = 0; k < 5; k++) chk("R1", "residency in reset", res_cycles[k*TS_W +: TS_W], 0);
  endtask

  task automatic t_open_close();
    do_act(2);
    chk("R3", "idle->act", cur_state, 3);
    chk("R3", "count after act", open_banks, 1);
    chk("R12", "stamp on act", last_chg_at, t);
    do_act(5);
    chk("R3", "second bank", open_banks, 2);
    do_act(2);
    chk("R3", "reopen open bank", open_banks, 2);
    do_pre(7);
    chk("R4", "close closed bank", open_banks, 2);
    chk("R4", "no booking", pend_vld, 0);
    do_pre(2);
    chk("R4", "close one", open_banks, 1);
    do_pre(5);
    chk("R4", "close last", open_banks, 0);
    chk("R5", "booked", pend_vld, 1);
    chk("R5", "booked state", pend_state, 0);
    chk("R5", "booked cycle", pend_at, t + PRE);
    chk("R2", "still active while booked", cur_state, 3);
    wait_to(t + PRE);
    chk("R5", "active before target", cur_state, 3);
    @(negedge clk);
    chk("R5", "idle at target", cur_state, 0);
    chk("R12", "stamp at target", last_chg_at, t + PRE);
    chk("R9", "no auto booking with delay 0", pend_vld, 0);
  endtask

  task automatic t_cancel();
    longint t0;
    do_act(1);
    do_pre(1);
    t0 = t;
    chk("R5", "booked for cancel", pend_at, t0 + PRE);
    do_act(3);
    chk("R6", "booking cancelled", pend_vld, 0);
    chk("R6", "count after late act", open_banks, 1);
    wait_to(t0 + PRE + 3);
    chk("R6", "stays active past old target", cur_state, 3);
    do_pre(3);
    chk("R6", "new target", pend_at, t + PRE);
    wait_to(t + PRE + 1);
    chk("R6", "idle at new target", cur_state, 0);
    do_act(0); do_act(4); do_act(6);
    chk("R3", "three open", open_banks, 3);
    do_pre_all();
    chk("R4", "close-all", open_banks, 0);
    chk("R5", "close-all books", pend_at, t + PRE);
    wait_to(t + PRE + 1);
    chk("R2", "idle after close-all", cur_state, 0);
  endtask

  task automatic t_ref_pdn();
    ref_start = 1; strobe_end();
    chk("R7", "refresh", cur_state, 1);
    ref_done = 1; strobe_end();
    chk("R7", "refresh done", cur_state, 0);
    pdn_req = 1; strobe_end();
    chk("R7", "pre pdn", cur_state, 2);
    do_act(1);
    chk("R10", "act in pre pdn ignored", cur_state, 2);
    chk("R10", "no bank opened", open_banks, 0);
    chk("R10", "err set", act_err, 1);
    pdn_exit = 1; strobe_end();
    chk("R7", "pdn exit", cur_state, 0);
    chk("R10", "err sticky", act_err, 1);
    do_act(2);
    pdn_req = 1; strobe_end();
    chk("R8", "act pdn", cur_state, 4);
    pdn_exit = 1; strobe_end();
    chk("R8", "exit to active", cur_state, 3);
    pdn_req = 1; strobe_end();
    do_pre_all();
    chk("R8", "no booking in act pdn", pend_vld, 0);
    pdn_exit = 1; strobe_end();
    chk("R8", "exit to idle", cur_state, 0);
  endtask

  task automatic t_auto_pdn();
    longint t1;
    pdn_dly = 8'd6;
    ref_start = 1; strobe_end();
    do_act(3);
    chk("R10", "act in refresh ignored", open_banks, 0);
    ref_done = 1; strobe_end();
    t1 = t;
    chk("R9", "auto booked", pend_vld, 1);
    chk("R9", "auto target state", pend_state, 2);
    chk("R9", "auto target cycle", pend_at, t1 + 6);
    wait_to(t1 + 7);
    chk("R9", "auto power-down", cur_state, 2);
    pdn_exit = 1; strobe_end();
    chk("R9", "rebooked", pend_at, t + 6);
    do_act(5);
    chk("R6", "act cancels auto booking", pend_vld, 0);
    chk("R6", "active", cur_state, 3);
    pdn_dly = 8'd0;
    do_pre_all();
    wait_to(t + PRE + 1);
    chk("R2", "idle at end", cur_state, 0);
  endtask

  task automatic t_residency();
    longint s = 0;
    for (int k = 0; k < 5; k++) begin
      chk("R11", "residency", res_cycles[k*TS_W +: TS_W], res_exp[k]);
      s += res_cycles[k*TS_W +: TS_W];
    end
    chk("R11", "residency sum", s, cyc);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_open_close();
    t_cancel();
    t_ref_pdn();
    t_auto_pdn();
    repeat (3) @(negedge clk);
    t_residency();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule